// File: doc/BRIEF.md
# BCD Calendar Clock Counter

This block keeps wall-clock time and calendar date in eight byte-wide registers, every count field in packed BCD. A sub-second base pulse enters the block, and an internal phase counter turns every `SUBTICKS`-th pulse into a one-second step. Each step carries through the chain in turn:

- seconds
- minutes
- hours
- weekday and date
- month
- year

The date rolls over at the true end of each month. February has 29 days when the year is a multiple of four.

A host loads any field through a one-cycle write port and reads any register through a combinational read port. A halt flag in the seconds register freezes the whole count. A format bit in the hours register selects 12-hour counting with a PM flag, or 24-hour counting. A control register only stores three output-control fields for a neighbouring square-wave generator. Its reserved bits read as zero.

Top module: `bcd_rtc_core`

## Requirements
- R1: After synchronous reset the registers read: seconds 0x00 (running), minutes 0x00, hours 0x00 (24-hour), weekday 0x01, date 0x01, month 0x01, year 0x00, control 0x00.
- R2: While not halted, the seconds register advances by one BCD count on every `SUBTICKS`-th cycle with `base_tick` high, and it holds at all other times unless it is written.
- R3: Seconds 59 steps to 00 and carries one into minutes. Minutes 59 steps to 00 on that carry and carries into hours. Both fields occupy bits 6:0.
- R4: In 24-hour mode (hours bit 6 = 0, hour 0–23 in bits 5:0), hour 23 steps to 00 on a carry and produces a day carry.
- R5: In 12-hour mode (hours bit 6 = 1, bit 5 = PM, hour 1–12 in bits 4:0), hour 11 steps to 12 and toggles PM, and hour 12 steps to 1. A day carry is produced only on the step from PM 11:59:59.
- R6: With bit 7 of the seconds register set, no register changes and the sub-second phase is frozen, apart from host writes.
- R7: On a day carry the weekday (address 3, bits 2:0) steps 1 to 7 and wraps from 7 back to 1.
- R8: On a day carry the date steps to 1 after the last day of the current month. That is day 30 for months 4, 6, 9 and 11, day 31 for the other months except February, and for February day 29 in years divisible by four and day 28 otherwise.
- R9: Month 12 wraps to 1 on a date wrap and carries into the year. Year 99 wraps to 00.
- R10: Register addresses are 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 date, 5 month, 6 year and 7 control. A write stores the data ANDed with the masks 0xFF, 0x7F, 0x7F, 0x07, 0x3F, 0x1F, 0xFF and 0x93 respectively, so unused bits read as zero. Control keeps bit 7, bit 4 and bits 1:0.
- R11: A write to the seconds register restarts the sub-second phase, so the next step comes exactly `SUBTICKS` base pulses after the write.
- R12: When a write and a one-second step fall in the same cycle, the written register takes the written value. Every other register advances as if no write had happened, with its carries derived from the pre-write values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_tick | input | 1 | Sub-second pulse; `SUBTICKS` pulses make one second |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address for the write |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Register address for the read |
| rd_data | output | 8 | Contents of the addressed register (combinational) |

## Verification
The count chain is exercised by loading times just short of each boundary. The bench then pulses the base tick until the boundary is crossed. The boundaries cover:

- the minute, hour and day edges in 24-hour mode;
- all four 12-hour transitions, which separate the PM toggle from the day carry;
- end-of-month dates in 30-day months, 31-day months, and February in leap and common years;
- the year-99 rollover.

Halting, partial sub-second phases before a seconds write, and writes that coincide with a step each expose a distinct ordering of the phase counter against the register update. Writes with all-ones in reserved positions show the masks.

// File: rtl/bcd_rtc_pkg.sv
package bcd_rtc_pkg;

    localparam logic [2:0] A_SEC   = 3'd0;
    localparam logic [2:0] A_MIN   = 3'd1;
    localparam logic [2:0] A_HOUR  = 3'd2;
    localparam logic [2:0] A_WDAY  = 3'd3;
    localparam logic [2:0] A_DATE  = 3'd4;
    localparam logic [2:0] A_MONTH = 3'd5;
    localparam logic [2:0] A_YEAR  = 3'd6;
    localparam logic [2:0] A_CTRL  = 3'd7;

    localparam logic [7:0] M_SEC   = 8'hFF;
    localparam logic [7:0] M_MIN   = 8'h7F;
    localparam logic [7:0] M_HOUR  = 8'h7F;
    localparam logic [7:0] M_WDAY  = 8'h07;
    localparam logic [7:0] M_DATE  = 8'h3F;
    localparam logic [7:0] M_MONTH = 8'h1F;
    localparam logic [7:0] M_YEAR  = 8'hFF;
    localparam logic [7:0] M_CTRL  = 8'h93;

    typedef struct packed {
        logic [7:0] sec;
        logic [7:0] min;
        logic [7:0] hour;
        logic [7:0] wday;
        logic [7:0] date;
        logic [7:0] month;
        logic [7:0] year;
        logic [7:0] ctrl;
    } rtc_regs_t;

    localparam rtc_regs_t RTC_RESET = '{
        sec: 8'h00, min: 8'h00, hour: 8'h00, wday: 8'h01,
        date: 8'h01, month: 8'h01, year: 8'h00, ctrl: 8'h00
    };

    // Two-digit BCD increment without range check.
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] >= 4'd9)
            return {v[7:4] + 4'd1, 4'h0};
        else
            return v + 8'd1;
    endfunction

    // Increment that returns to 'first' after reaching 'last'.
    function automatic logic [7:0] bcd_wrap(input logic [7:0] v,
                                            input logic [7:0] last,
                                            input logic [7:0] first);
        return (v == last) ? first : bcd_inc(v);
    endfunction

    function automatic logic is_leap(input logic [7:0] yr);
        logic [6:0] bin;
        bin = 7'(yr[7:4]) * 7'd10 + 7'(yr[3:0]);
        return bin[1:0] == 2'b00;
    endfunction

    // Last day of a month, as a BCD byte.
    function automatic logic [7:0] last_day(input logic [7:0] mon,
                                            input logic [7:0] yr);
        case (mon)
            8'h02:                      return is_leap(yr) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_phase_div.sv
module rtc_phase_div #(
    parameter int SUBTICKS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic base_tick,
    input  logic halt,
    input  logic restart,
    output logic sec_step
);
    localparam int CW = (SUBTICKS > 1) ? $clog2(SUBTICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(SUBTICKS - 1);

    logic [CW-1:0] phase_q;
    logic          run;

    assign run      = base_tick && !halt;
    assign sec_step = run && (phase_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || restart)
            phase_q <= '0;
        else if (run)
            phase_q <= (phase_q == LAST) ? '0 : phase_q + CW'(1);
    end
endmodule

// File: rtl/rtc_time_chain.sv
module rtc_time_chain (
    input  logic [7:0] sec,
    input  logic [7:0] min,
    input  logic [6:0] hour,
    input  logic       step,
    output logic [7:0] sec_n,
    output logic [7:0] min_n,
    output logic [7:0] hour_n,
    output logic       day_carry
);
    import bcd_rtc_pkg::*;

    logic       sec_carry, min_carry;
    logic [7:0] sec_inc, min_inc, h12_inc, h24_inc;
    logic [7:0] h12, h24;
    logic       pm, pm_n;

    assign sec_carry = step && (sec[6:0] == 7'h59);
    assign min_carry = sec_carry && (min == 8'h59);

    assign sec_inc = bcd_wrap({1'b0, sec[6:0]}, 8'h59, 8'h00);
    assign min_inc = bcd_wrap(min, 8'h59, 8'h00);
    assign sec_n   = step ? ({sec[7], 7'h00} | (sec_inc & 8'h7F)) : sec;
    assign min_n   = sec_carry ? min_inc : min;

    assign h12     = {3'b000, hour[4:0]};
    assign h24     = {2'b00, hour[5:0]};
    assign pm      = hour[5];
    assign h12_inc = bcd_wrap(h12, 8'h12, 8'h01);
    assign h24_inc = bcd_wrap(h24, 8'h23, 8'h00);
    assign pm_n    = (h12 == 8'h11) ? !pm : pm;

    always_comb begin
        hour_n    = {1'b0, hour};
        day_carry = 1'b0;
        if (min_carry) begin
            if (hour[6]) begin
                hour_n    = {2'b01, pm_n, 5'h00} | (h12_inc & 8'h1F);
                day_carry = (h12 == 8'h11) && pm;
            end else begin
                hour_n    = h24_inc & 8'h3F;
                day_carry = (h24 == 8'h23);
            end
        end
    end
endmodule

// File: rtl/rtc_date_chain.sv
module rtc_date_chain (
    input  logic [7:0] wday,
    input  logic [7:0] date,
    input  logic [7:0] month,
    input  logic [7:0] year,
    input  logic       day_carry,
    output logic [7:0] wday_n,
    output logic [7:0] date_n,
    output logic [7:0] month_n,
    output logic [7:0] year_n
);
    import bcd_rtc_pkg::*;

    logic date_end, mon_carry, year_carry;

    assign date_end   = (date == last_day(month, year));
    assign mon_carry  = day_carry && date_end;
    assign year_carry = mon_carry && (month == 8'h12);

    assign wday_n  = !day_carry ? wday : ((wday == 8'h07) ? 8'h01 : wday + 8'h01);
    assign date_n  = !day_carry ? date : (date_end ? 8'h01 : bcd_inc(date));
    assign month_n = mon_carry  ? bcd_wrap(month, 8'h12, 8'h01) : month;
    assign year_n  = year_carry ? bcd_wrap(year, 8'h99, 8'h00) : year;
endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core #(
    parameter int SUBTICKS = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       base_tick,
    input  logic       wr_en,
    input  logic [2:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic [2:0] rd_addr,
    output logic [7:0] rd_data
);
    import bcd_rtc_pkg::*;

    rtc_regs_t  regs_q, regs_d;
    logic       sec_step, day_carry, sec_wr;
    logic [7:0] t_sec, t_min, t_hour;
    logic [7:0] d_wday, d_date, d_month, d_year;

    assign sec_wr = wr_en && (wr_addr == A_SEC);

    rtc_phase_div #(.SUBTICKS(SUBTICKS)) i_phase (
        .clk      (clk),
        .rst      (rst),
        .base_tick(base_tick),
        .halt     (regs_q.sec[7]),
        .restart  (sec_wr),
        .sec_step (sec_step)
    );

    rtc_time_chain i_time (
        .sec      (regs_q.sec),
        .min      (regs_q.min),
        .hour     (regs_q.hour[6:0]),
        .step     (sec_step),
        .sec_n    (t_sec),
        .min_n    (t_min),
        .hour_n   (t_hour),
        .day_carry(day_carry)
    );

    rtc_date_chain i_date (
        .wday     (regs_q.wday),
        .date     (regs_q.date),
        .month    (regs_q.month),
        .year     (regs_q.year),
        .day_carry(day_carry),
        .wday_n   (d_wday),
        .date_n   (d_date),
        .month_n  (d_month),
        .year_n   (d_year)
    );

    always_comb begin
        regs_d       = regs_q;
        regs_d.sec   = t_sec;
        regs_d.min   = t_min;
        regs_d.hour  = t_hour;
        regs_d.wday  = d_wday;
        regs_d.date  = d_date;
        regs_d.month = d_month;
        regs_d.year  = d_year;
        if (wr_en) begin
            case (wr_addr)
                A_SEC:   regs_d.sec   = wr_data & M_SEC;
                A_MIN:   regs_d.min   = wr_data & M_MIN;
                A_HOUR:  regs_d.hour  = wr_data & M_HOUR;
                A_WDAY:  regs_d.wday  = wr_data & M_WDAY;
                A_DATE:  regs_d.date  = wr_data & M_DATE;
                A_MONTH: regs_d.month = wr_data & M_MONTH;
                A_YEAR:  regs_d.year  = wr_data & M_YEAR;
                default: regs_d.ctrl  = wr_data & M_CTRL;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            regs_q <= RTC_RESET;
        else
            regs_q <= regs_d;
    end

    always_comb begin
        case (rd_addr)
            A_SEC:   rd_data = regs_q.sec;
            A_MIN:   rd_data = regs_q.min;
            A_HOUR:  rd_data = regs_q.hour;
            A_WDAY:  rd_data = regs_q.wday;
            A_DATE:  rd_data = regs_q.date;
            A_MONTH: rd_data = regs_q.month;
            A_YEAR:  rd_data = regs_q.year;
            default: rd_data = regs_q.ctrl;
        endcase
    end
endmodule

// File: rtl/bcd_rtc_checker.sv
module bcd_rtc_checker (
    input logic                  clk,
    input logic                  rst,
    input logic                  wr_en,
    input logic [2:0]            rd_addr,
    input logic [7:0]            rd_data,
    input bcd_rtc_pkg::rtc_regs_t regs_q,
    input logic                  sec_step,
    input logic                  day_carry
);
    assert_wday_reserved_R10: assert property (@(posedge clk) disable iff (rst)
        (rd_addr == 3'd3) |-> (rd_data[7:3] == 5'd0));

    assert_ctrl_reserved_R10: assert property (@(posedge clk) disable iff (rst)
        (rd_addr == 3'd7) |-> ((rd_data & 8'h6C) == 8'h00));

    assert_sec_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !sec_step) |=> $stable(regs_q.sec));

    assert_sec_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && sec_step && regs_q.sec[6:0] == 7'h59) |=> (regs_q.sec[6:0] == 7'h00));

    assert_halt_freeze_R6: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && regs_q.sec[7]) |=> $stable(regs_q));

    assert_wday_wrap_R7: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && day_carry && regs_q.wday == 8'h07) |=> (regs_q.wday == 8'h01));
endmodule

bind bcd_rtc_core bcd_rtc_checker i_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .regs_q   (regs_q),
    .sec_step (sec_step),
    .day_carry(day_carry)
);

// File: tb/test_bcd_rtc_core.sv
`timescale 1ns/1ps
module test_bcd_rtc_core;
    localparam int SUB = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       base_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = 3'd0;
    logic [7:0] wr_data = 8'h00;
    logic [2:0] rd_addr = 3'd0;
    logic [7:0] rd_data;

    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    string cur_req = "R1";

    // behavioural reference state, decimal values
    int m_sec, m_min, m_hr, m_wd, m_date, m_mon, m_yr, m_cnt;
    bit m_ch, m_12, m_pm;
    logic [7:0] m_ctrl;

    bcd_rtc_core #(.SUBTICKS(SUB)) i_bcd_rtc_core (
        .clk(clk), .rst(rst), .base_tick(base_tick), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    always #2 clk = ~clk;

    function automatic logic [7:0] to_bcd(input int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic int from_bcd(input logic [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction

    function automatic int month_len(input int mo, input int yr);
        if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    task automatic model_reset();
        m_sec = 0; m_ch = 0; m_min = 0; m_hr = 0; m_12 = 0; m_pm = 0;
        m_wd = 1; m_date = 1; m_mon = 1; m_yr = 0; m_ctrl = 8'h00; m_cnt = 0;
    endtask

    task automatic advance_second();
        bit dc;
        dc = 0;
        m_sec++;
        if (m_sec < 60) return;
        m_sec = 0;
        m_min++;
        if (m_min < 60) return;
        m_min = 0;
        if (m_12) begin
            if (m_hr == 11) begin m_hr = 12; dc = m_pm; m_pm = !m_pm; end
            else if (m_hr == 12) m_hr = 1;
            else m_hr++;
        end else begin
            m_hr++;
            if (m_hr == 24) begin m_hr = 0; dc = 1; end
        end
        if (!dc) return;
        m_wd = (m_wd == 7) ? 1 : m_wd + 1;
        if (m_date == month_len(m_mon, m_yr)) begin
            m_date = 1;
            m_mon++;
            if (m_mon == 13) begin m_mon = 1; m_yr = (m_yr + 1) % 100; end
        end else begin
            m_date++;
        end
    endtask

    task automatic apply_write(input logic [2:0] a, input logic [7:0] d);
        case (a)
            3'd0: begin m_ch = d[7]; m_sec = from_bcd(d & 8'h7F); end
            3'd1: m_min = from_bcd(d & 8'h7F);
            3'd2: begin
                m_12 = d[6];
                if (m_12) begin m_pm = d[5]; m_hr = from_bcd(d & 8'h1F); end
                else begin m_pm = 0; m_hr = from_bcd(d & 8'h3F); end
            end
            3'd3: m_wd = int'(d & 8'h07);
            3'd4: m_date = from_bcd(d & 8'h3F);
            3'd5: m_mon = from_bcd(d & 8'h1F);
            3'd6: m_yr = from_bcd(d);
            default: m_ctrl = d & 8'h93;
        endcase
    endtask

    task automatic model_update(input bit tk, input bit we, input logic [2:0] a,
                                input logic [7:0] d);
        bit adv;
        adv = tk && !m_ch && (m_cnt == SUB - 1);
        if (tk && !m_ch) m_cnt = (m_cnt == SUB - 1) ? 0 : m_cnt + 1;
        if (we && a == 3'd0) m_cnt = 0;
        if (adv) advance_second();
        if (we) apply_write(a, d);
    endtask

    function automatic logic [7:0] expected(input int a);
        case (a)
            0: return {m_ch, 7'(to_bcd(m_sec))};
            1: return to_bcd(m_min);
            2: return m_12 ? (8'h40 | {2'b00, m_pm, 5'h00} | to_bcd(m_hr)) : to_bcd(m_hr);
            3: return 8'(m_wd);
            4: return to_bcd(m_date);
            5: return to_bcd(m_mon);
            6: return to_bcd(m_yr);
            default: return m_ctrl;
        endcase
    endfunction

    task automatic check_all();
        for (int a = 0; a < 8; a++) begin
            rd_addr = 3'(a);
            #0.1;
            checks++;
            if (rd_data !== expected(a)) begin
                errors++;
                $display("FAIL %s reg %0d: actual %02h expected %02h", cur_req, a,
                         rd_data, expected(a));
            end
        end
    endtask

    task automatic step(input bit tk, input bit we, input logic [2:0] a,
                        input logic [7:0] d);
        @(negedge clk);
        base_tick = tk; wr_en = we; wr_addr = a; wr_data = d;
        @(posedge clk);
        model_update(tk, we, a, d);
        #0.5;
        check_all();
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        step(1'b0, 1'b1, a, d);
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            step(1'b1, 1'b0, 3'd0, 8'h00);
            step(1'b0, 1'b0, 3'd0, 8'h00);
        end
    endtask

    // hours, minutes, then seconds last so the phase restarts
    task automatic set_time(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
        wr(3'd2, h); wr(3'd1, m); wr(3'd0, s);
    endtask

    task automatic set_day(input logic [7:0] dt, input logic [7:0] mo, input logic [7:0] yr);
        wr(3'd6, yr); wr(3'd5, mo); wr(3'd4, dt);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        #0.5;
        cur_req = "R1";                       // reset values
        check_all();
        @(negedge clk);
        rst = 1'b0;

        cur_req = "R2";                       // one step per SUB pulses
        pulses(10);
        step(1'b1, 1'b0, 3'd0, 8'h00);
        step(1'b1, 1'b0, 3'd0, 8'h00);        // back-to-back pulses

        cur_req = "R3";                       // second and minute carries
        set_time(8'h05, 8'h59, 8'h57);
        pulses(4 * SUB);

        cur_req = "R4";                       // 24-hour day carry
        wr(3'd3, 8'h06);
        set_day(8'h14, 8'h07, 8'h31);
        set_time(8'h23, 8'h59, 8'h58);
        pulses(3 * SUB);

        cur_req = "R7";                       // weekday 7 -> 1
        set_time(8'h23, 8'h59, 8'h59);
        pulses(SUB);

        cur_req = "R5";                       // 12-hour sequence
        set_time(8'h51, 8'h59, 8'h59); pulses(SUB);   // AM 11 -> PM 12
        set_time(8'h72, 8'h59, 8'h59); pulses(SUB);   // PM 12 -> PM 1
        set_time(8'h71, 8'h59, 8'h59); pulses(SUB);   // PM 11 -> AM 12, day carry
        set_time(8'h52, 8'h59, 8'h59); pulses(SUB);   // AM 12 -> AM 1
        set_time(8'h71, 8'h59, 8'h59); pulses(SUB);   // again, another day

        cur_req = "R8";                       // month lengths and leap years
        set_day(8'h28, 8'h02, 8'h24); set_time(8'h23, 8'h59, 8'h59); pulses(SUB);
        set_day(8'h29, 8'h02, 8'h24); set_time(8'h23, 8'h59, 8'h59); pulses(SUB);
        set_day(8'h28, 8'h02, 8'h23); set_time(8'h23, 8'h59, 8'h59); pulses(SUB);
        set_day(8'h28, 8'h02, 8'h00); set_time(8'h23, 8'h59, 8'h59); pulses(SUB);
        set_day(8'h30, 8'h04, 8'h10); set_time(8'h23, 8'h59, 8'h59); pulses(SUB);
        set_day(8'h30, 8'h11, 8'h10); set_time(8'h23, 8'h59, 8'h59); pulses(SUB);
        set_day(8'h30, 8'h01, 8'h10); set_time(8'h23, 8'h59, 8'h59); pulses(SUB);
        set_day(8'h31, 8'h01, 8'h10); set_time(8'h23, 8'h59, 8'h59); pulses(SUB);

        cur_req = "R9";                       // month and year wrap
        set_day(8'h31, 8'h12, 8'h99); set_time(8'h23, 8'h59, 8'h59); pulses(SUB);
        set_day(8'h31, 8'h12, 8'h45); set_time(8'h71, 8'h59, 8'h59); pulses(SUB);

        cur_req = "R6";                       // halt freezes count and phase
        set_time(8'h10, 8'h20, 8'h83);
        pulses(3 * SUB);
        wr(3'd7, 8'h10);
        pulses(2);
        wr(3'd0, 8'h03);
        pulses(SUB + 1);

        cur_req = "R10";                      // write masks
        wr(3'd3, 8'hFD);
        wr(3'd7, 8'hFF);
        wr(3'd1, 8'hD9);
        wr(3'd2, 8'h92);
        wr(3'd4, 8'hF1);
        wr(3'd5, 8'hE2);
        wr(3'd0, 8'h45);
        wr(3'd7, 8'h6C);

        cur_req = "R11";                      // seconds write restarts the phase
        pulses(2);
        wr(3'd0, 8'h10);
        pulses(SUB - 1);
        pulses(1);
        pulses(SUB - 2);
        wr(3'd1, 8'h05);                      // other writes leave phase alone
        pulses(2);

        cur_req = "R12";                      // write coinciding with a step
        set_time(8'h10, 8'h29, 8'h59);
        pulses(SUB - 1);
        step(1'b1, 1'b1, 3'd1, 8'h40);        // minute write beats carry
        step(1'b0, 1'b0, 3'd0, 8'h00);
        set_time(8'h10, 8'h29, 8'h59);
        pulses(SUB - 1);
        step(1'b1, 1'b1, 3'd0, 8'h20);        // seconds write, minutes still carry
        pulses(SUB);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule